// File: doc/BRIEF.md
# Boot-Time Parallel ROM Configuration Loader

This block fills a chip's configuration registers at power-up. Once the synchronous system reset is released it samples a mode input. In ROM-boot mode it becomes master of an external byte-wide parallel ROM. It walks the locations one after another. For each one it presents the address, pulls the shared chip-select/output-enable line low and holds it low for a fixed number of clock cycles that covers the ROM's worst-case access time. It then captures the byte and writes it into the register file through a single-cycle write port. In pin mode no ROM cycle is made: the value on the configuration pins is written to register 0 and the block finishes at once.

The wait is not a handshake. Its length is worked out at elaboration from the access time and the clock period, rounded up, plus one cycle of margin. At the default 5 ns clock and 590 ns access time this gives 119 cycles. A `done` flag tells the rest of the chip that its registers are valid. A reset at any point aborts the load, and the next release starts it again from location 0.

Top module: `cfg_boot_loader`

## Requirements
- R1: With `boot_sel`=1 sampled on the first rising edge after `rst` falls, `rom_oe_n` goes low on the second such edge, with `rom_addr`=0.
- R2: Locations 0 to N_LOC-1 (default 128) are read in ascending order, with exactly one register write per location, and `reg_waddr` equals the location read.
- R3: Each read holds `rom_oe_n` low for exactly WAIT_CYC cycles, where WAIT_CYC = ceil(ACCESS_PS/CLK_PS)+1 (119 by default). `reg_wdata` is the byte on `rom_data` at the edge that ends the low window. A byte that becomes valid only on that edge is still captured.
- R4: Between two reads `rom_oe_n` stays high for at least one cycle. `rom_addr` changes only while `rom_oe_n` is high.
- R5: `reg_we` is a one-cycle pulse, asserted in the cycle in which `rom_oe_n` has just returned high.
- R6: `done` rises one cycle after the last write and stays high until reset. While `done` is high, `rom_oe_n`=1 and `reg_we`=0.
- R7: With `boot_sel`=0 sampled on the first edge after reset release, `rom_oe_n` never goes low. `cfg_pins` is written once to address 0 on that edge, and `done` rises on the next edge.
- R8: A rising edge with `rst`=1 sets `rom_oe_n`=1, `rom_addr`=0, `reg_we`=0 and `done`=0. A load that is cut off this way starts again from location 0 after release.
- R9: Changes of `boot_sel` after the first edge following reset release have no effect on the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high system reset |
| boot_sel | input | 1 | 1 = load from ROM, 0 = take configuration pins |
| cfg_pins | input | DATA_W | Default configuration value used in pin mode |
| rom_data | input | DATA_W | Data bus from the external ROM |
| rom_addr | output | ADDR_W | Address to the external ROM |
| rom_oe_n | output | 1 | Active-low chip select / output enable to the ROM |
| reg_we | output | 1 | Register-file write strobe |
| reg_waddr | output | ADDR_W | Register-file write address |
| reg_wdata | output | DATA_W | Register-file write data |
| done | output | 1 | Configuration complete |

## Verification
On every cycle the assertions check the following properties. The address stays still while output enable is low. Each rising edge of output enable comes with a write pulse and is followed by a high cycle. Write pulses last one cycle. `done` is sticky, and the bus is idle while `done` is high. A reset edge returns all outputs to idle. Other properties only the bench scenarios can show. One is the exact length of the enable window, checked against a ROM model that returns garbage until the access time has passed. The others are the complete ascending set of 128 written bytes, the pin-mode path, indifference to late mode changes, and a clean restart after a reset that lands mid-load.

// File: rtl/cfg_boot_pkg.sv
package cfg_boot_pkg;

  typedef enum logic [2:0] {
    ST_START  = 3'd0,
    ST_SETUP  = 3'd1,
    ST_ACCESS = 3'd2,
    ST_STEP   = 3'd3,
    ST_PINW   = 3'd4,
    ST_DONE   = 3'd5
  } boot_state_e;

  // Worst-case access time rounded up to whole clocks, plus one cycle of margin.
  function automatic int access_cycles(input int access_ps, input int clk_ps);
    return (access_ps + clk_ps - 1) / clk_ps + 1;
  endfunction

endpackage

// File: rtl/cfg_wait_timer.sv
module cfg_wait_timer #(
  parameter int CNT_W    = 7,
  parameter int LOAD_VAL = 118
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic expired
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (start) begin
      cnt_q <= CNT_W'(LOAD_VAL);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/cfg_addr_counter.sv
module cfg_addr_counter #(
  parameter int ADDR_W = 7,
  parameter int LAST   = 127
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inc,
  output logic [ADDR_W-1:0] addr,
  output logic              at_last
);

  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
    end else if (inc) begin
      addr_q <= addr_q + 1'b1;
    end
  end

  assign addr    = addr_q;
  assign at_last = (addr_q == ADDR_W'(LAST));

endmodule

// File: rtl/cfg_boot_loader.sv
module cfg_boot_loader #(
  parameter int ADDR_W    = 7,
  parameter int DATA_W    = 8,
  parameter int N_LOC     = 128,
  parameter int CLK_PS    = 5000,
  parameter int ACCESS_PS = 590000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              boot_sel,
  input  logic [DATA_W-1:0] cfg_pins,
  input  logic [DATA_W-1:0] rom_data,
  output logic [ADDR_W-1:0] rom_addr,
  output logic              rom_oe_n,
  output logic              reg_we,
  output logic [ADDR_W-1:0] reg_waddr,
  output logic [DATA_W-1:0] reg_wdata,
  output logic              done
);

  import cfg_boot_pkg::*;

  localparam int WAIT_CYC = access_cycles(ACCESS_PS, CLK_PS);
  localparam int TMR_W    = $clog2(WAIT_CYC + 1);
  localparam int LAST_LOC = N_LOC - 1;

  boot_state_e state_q;
  logic        tmr_start;
  logic        tmr_expired;
  logic        addr_inc;
  logic        addr_last;

  cfg_wait_timer #(
    .CNT_W   (TMR_W),
    .LOAD_VAL(WAIT_CYC - 1)
  ) u_timer (
    .clk    (clk),
    .rst    (rst),
    .start  (tmr_start),
    .expired(tmr_expired)
  );

  cfg_addr_counter #(
    .ADDR_W(ADDR_W),
    .LAST  (LAST_LOC)
  ) u_addr (
    .clk    (clk),
    .rst    (rst),
    .inc    (addr_inc),
    .addr   (rom_addr),
    .at_last(addr_last)
  );

  always_comb begin
    tmr_start = (state_q == ST_SETUP);
    addr_inc  = (state_q == ST_STEP) && !addr_last;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_START;
      rom_oe_n  <= 1'b1;
      reg_we    <= 1'b0;
      reg_waddr <= '0;
      reg_wdata <= '0;
      done      <= 1'b0;
    end else begin
      case (state_q)
        ST_START: begin
          if (boot_sel) begin
            state_q <= ST_SETUP;
          end else begin
            reg_we    <= 1'b1;
            reg_waddr <= '0;
            reg_wdata <= cfg_pins;
            state_q   <= ST_PINW;
          end
        end
        ST_SETUP: begin
          rom_oe_n <= 1'b0;
          state_q  <= ST_ACCESS;
        end
        ST_ACCESS: begin
          if (tmr_expired) begin
            rom_oe_n  <= 1'b1;
            reg_we    <= 1'b1;
            reg_waddr <= rom_addr;
            reg_wdata <= rom_data;
            state_q   <= ST_STEP;
          end
        end
        ST_STEP: begin
          reg_we <= 1'b0;
          if (addr_last) begin
            done    <= 1'b1;
            state_q <= ST_DONE;
          end else begin
            state_q <= ST_SETUP;
          end
        end
        ST_PINW: begin
          reg_we  <= 1'b0;
          done    <= 1'b1;
          state_q <= ST_DONE;
        end
        ST_DONE: state_q <= ST_DONE;
        default: state_q <= ST_START;
      endcase
    end
  end

  // R4: address must hold while the ROM output is enabled
  a_r4_addr_stable: assert property (@(posedge clk) disable iff (rst)
    (!rom_oe_n && !$past(rom_oe_n)) |-> $stable(rom_addr));

  // R4: after output enable returns high it stays high one more cycle
  a_r4_oe_gap: assert property (@(posedge clk) disable iff (rst)
    $rose(rom_oe_n) |=> rom_oe_n);

  // R5: every end of a read window comes with a write strobe
  a_r5_we_on_oe_rise: assert property (@(posedge clk) disable iff (rst)
    $rose(rom_oe_n) |-> reg_we);

  // R5: write strobe is a single cycle
  a_r5_we_single: assert property (@(posedge clk) disable iff (rst)
    reg_we |=> !reg_we);

  // R6: done is sticky and the bus is idle while it is set
  a_r6_done_sticky: assert property (@(posedge clk) disable iff (rst)
    done |=> done);

  a_r6_done_quiet: assert property (@(posedge clk) disable iff (rst)
    done |-> (rom_oe_n && !reg_we));

  // R8: a reset edge returns the outputs to idle
  a_r8_reset_idle: assert property (@(posedge clk)
    rst |=> (rom_oe_n && !reg_we && !done && rom_addr == '0));

endmodule

// File: tb/sim_cfg_boot_loader.sv
`timescale 1ns/1ps
module sim_cfg_boot_loader;

  localparam int AW   = 7;
  localparam int DW   = 8;
  localparam int NLOC = 128;
  localparam int ACC  = (590000 + 4999) / 5000;  // 118 cycles of raw access time
  localparam int WAIT = ACC + 1;                 // 119
  localparam int PER  = WAIT + 2;                // cycles per location

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          boot_sel = 1'b1;
  logic [DW-1:0] cfg_pins = '0;
  logic [DW-1:0] rom_data = '0;
  logic [AW-1:0] rom_addr;
  logic          rom_oe_n;
  logic          reg_we;
  logic [AW-1:0] reg_waddr;
  logic [DW-1:0] reg_wdata;
  logic          done;

  int errs = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  cfg_boot_loader u0 (
    .clk(clk), .rst(rst), .boot_sel(boot_sel), .cfg_pins(cfg_pins),
    .rom_data(rom_data), .rom_addr(rom_addr), .rom_oe_n(rom_oe_n),
    .reg_we(reg_we), .reg_waddr(reg_waddr), .reg_wdata(reg_wdata), .done(done)
  );

  function automatic logic [DW-1:0] rom_byte(input int a);
    return DW'(a * 37 + 11);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // input samples as the design sees them
  logic          rst_s = 1'b1;
  logic          mode_s = 1'b1;
  logic [DW-1:0] pins_s = '0;
  bit            started = 0;
  always @(posedge clk) begin
    rst_s   <= rst;
    mode_s  <= boot_sel;
    pins_s  <= cfg_pins;
    started <= 1'b1;
  end

  // reference model and statistics
  int      t = 0;
  bit      mode_l = 1'b1;
  logic [DW-1:0] pins_l = '0;
  int      wq_a[$];
  int      wq_d[$];
  int      low_run = 0, high_run = 0, n_reads = 0, len_bad = 0, gap_bad = 0;
  bit      seen_low = 0;
  int      rom_low = 0;

  always @(negedge clk) begin
    if (started) begin
      int u, i, r;
      bit e_oe, e_we, e_done;
      int e_addr, e_wa, e_wd;
      string tag;
      if (rst_s) begin
        t = 0; wq_a.delete(); wq_d.delete();
        low_run = 0; high_run = 0; n_reads = 0; len_bad = 0; gap_bad = 0; seen_low = 0;
      end else begin
        t++;
        if (t == 1) begin mode_l = mode_s; pins_l = pins_s; end
      end
      e_oe = 1; e_we = 0; e_done = 0; e_addr = 0; e_wa = 0; e_wd = 0; tag = "R8";
      if (t > 0) begin
        if (!mode_l) begin
          tag = "R7";
          if (t == 1) begin e_we = 1; e_wd = int'(pins_l); end
          else e_done = 1;
        end else if (t >= 2) begin
          u = t - 2; i = u / PER; r = u % PER;
          if (i >= NLOC) begin e_addr = NLOC - 1; e_done = 1; tag = "R6"; end
          else if (r < WAIT) begin e_oe = 0; e_addr = i; tag = "R3"; end
          else if (r == WAIT) begin
            e_addr = i; e_we = 1; e_wa = i; e_wd = int'(rom_byte(i)); tag = "R5";
          end else begin
            tag = "R4";
            if (i == NLOC - 1) begin e_addr = NLOC - 1; e_done = 1; end
            else e_addr = i + 1;
          end
        end else tag = "R1";
      end
      chk(rom_oe_n === e_oe, tag, "rom_oe_n", int'(rom_oe_n), int'(e_oe));
      chk(rom_addr === AW'(e_addr), tag, "rom_addr", int'(rom_addr), e_addr);
      chk(reg_we === e_we, tag, "reg_we", int'(reg_we), int'(e_we));
      chk(done === e_done, tag, "done", int'(done), int'(e_done));
      if (e_we) begin
        chk(reg_waddr === AW'(e_wa), "R2", "reg_waddr", int'(reg_waddr), e_wa);
        chk(reg_wdata === DW'(e_wd), "R3", "reg_wdata", int'(reg_wdata), e_wd);
      end
      if (!rst_s) begin
        if (reg_we) begin wq_a.push_back(int'(reg_waddr)); wq_d.push_back(int'(reg_wdata)); end
        if (!rom_oe_n) begin
          if (low_run == 0 && seen_low && high_run < 1) gap_bad++;
          low_run++; high_run = 0; seen_low = 1;
        end else begin
          if (low_run != 0) begin
            n_reads++;
            if (low_run != WAIT) len_bad++;
          end
          low_run = 0; high_run++;
        end
      end
      // ROM model: garbage until the access time has fully elapsed
      if (!rom_oe_n) rom_low++; else rom_low = 0;
      rom_data = (rom_low > ACC) ? rom_byte(int'(rom_addr)) : ~rom_byte(int'(rom_addr));
    end
  end

  task automatic cycles(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wait_done(input int limit, input string req);
    int k = 0;
    while (done !== 1'b1 && k < limit) begin @(negedge clk); k++; end
    chk(done === 1'b1, req, "done reached", int'(done), 1);
  endtask

  task automatic check_full_load(input string req);
    int bad = 0;
    for (int i = 0; i < wq_a.size(); i++)
      if (wq_a[i] != i || wq_d[i] != int'(rom_byte(i))) bad++;
    chk(wq_a.size() == NLOC, "R2", {req, " write count"}, wq_a.size(), NLOC);
    chk(bad == 0, "R2", {req, " ascending writes"}, bad, 0);
    chk(n_reads == NLOC, "R3", {req, " read windows"}, n_reads, NLOC);
    chk(len_bad == 0, "R3", {req, " window length"}, len_bad, 0);
    chk(gap_bad == 0, "R4", {req, " gap between reads"}, gap_bad, 0);
  endtask

  initial begin
    #1000000;
    checks++; errs++;
    $display("FAIL watchdog expired: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    // reset state (R8)
    cycles(4);
    @(negedge clk);
    chk(rom_oe_n === 1'b1 && reg_we === 1'b0 && done === 1'b0 && rom_addr === '0,
        "R8", "idle during reset", int'(rom_oe_n), 1);

    // scenario 1: full ROM load (R1, R2, R3, R4, R5)
    cycles(1);
    rst = 1'b0;
    wait_done(20000, "R1");
    check_full_load("R1 run");
    cycles(50);
    @(negedge clk);
    chk(done === 1'b1 && rom_oe_n === 1'b1, "R6", "done held, bus idle", int'(done), 1);

    // scenario 2: late mode change ignored (R9), abort mid-load (R8)
    cycles(1);
    rst = 1'b1; cycles(3); rst = 1'b0;
    cycles(10);
    boot_sel = 1'b0;                                // R9: too late to matter
    cycles(3000);
    chk(wq_a.size() > 0 && done === 1'b0, "R9", "load continues after mode change",
        wq_a.size(), 24);
    rst = 1'b1; boot_sel = 1'b1; cycles(2); rst = 1'b0;
    wait_done(20000, "R8");
    check_full_load("R8 restart");

    // scenario 3: pin mode (R7)
    cycles(1);
    rst = 1'b1; boot_sel = 1'b0; cfg_pins = 8'h5C; cycles(3); rst = 1'b0;
    cycles(20);
    @(negedge clk);
    chk(wq_a.size() == 1, "R7", "pin-mode write count", wq_a.size(), 1);
    if (wq_a.size() >= 1)
      chk(wq_a[0] == 0 && wq_d[0] == 'h5C, "R7", "pin-mode value", wq_d[0], 'h5C);
    chk(n_reads == 0 && seen_low == 0, "R7", "no ROM access", n_reads, 0);
    chk(done === 1'b1, "R6", "done in pin mode", int'(done), 1);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule